// File: doc/BRIEF.md
# Convolution Window Feeder

This block sits between a raster-ordered feature-map stream and a convolution or pooling compute stage. Pixels arrive one word at a time over a valid/ready input, channel innermost, then column, then row. The block keeps only as many image rows as the kernel is tall, in a small rotating row store. Each time the rows it holds contain a complete kernel-sized neighbourhood, it replays that neighbourhood word by word to the compute stage over a second valid/ready stream.

Operation alternates between two phases. In the fill phase the block accepts input until the window for the next output position is complete. In the emit phase the input is held off while the window is sent in a fixed order. Output positions advance in raster order at stride 1 with no padding. After the last window of a frame, all pointers return to their start, so the next frame can follow at once. The kernel size, image size and channel count are parameters. Words are 16-bit fixed point and pass through unchanged.

Top module: `conv_window_feeder`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `win_valid` is 0.
- R2: `in_ready` and `win_valid` are never high together. The first window of a frame starts only after exactly ((KH-1)*IMG_W + KW)*CH input words of that frame have been accepted.
- R3: Element e of the window for output position (oy, ox) carries the input word at row oy+ky, column ox+kx, channel c. Here ky = e / (KW*CH), kx = (e / CH) mod KW and c = e mod CH, so ky is outermost and the channel is innermost.
- R4: `win_last` is 1 on element KH*KW*CH-1 of each window and 0 on every other element.
- R5: Between two windows in the same output row, exactly CH further input words are accepted. When the output row advances, exactly KW*CH are accepted.
- R6: Each frame yields (IMG_H-KH+1)*(IMG_W-KW+1) windows, with ox running fastest. The last window ends after the final input word of the frame has been accepted.
- R7: While `win_valid` is 1 and `win_ready` is 0, the next cycle keeps `win_valid` at 1 with `win_data` and `win_last` unchanged. No element is dropped or reordered.
- R8: After the last window of a frame, the block returns to the fill phase with `in_ready` at 1. The next frame's first window then again needs the full initial fill of R2.
- R9: All 16 data bits, including all-ones, all-zeros and sign-bit-only patterns, reach `win_data` unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts input (fill phase) |
| in_data | input | 16 | Input pixel word, raster order, channel innermost |
| win_valid | output | 1 | Window element present (emit phase) |
| win_ready | input | 1 | Compute stage accepts window element |
| win_data | output | 16 | Window element word |
| win_last | output | 1 | Final element of the current window |

## Verification
Any wrong internal state shows up at the ports within one window. A row slot that rotates wrongly, or a column offset that is off, puts a wrong word on `win_data` at the first element that reads the bad location. That happens no later than the next window. A fill counter that miscounts shifts the input count seen at the first element of a window, so the count check catches it at once. A walker that forgets its place under backpressure alters `win_data` in the cycle after a stall.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

    // index width that never collapses to zero bits
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cwf_row_store.sv
module cwf_row_store
    import cwf_pkg::*;
#(
    parameter int ROWS      = 3,
    parameter int ROW_ELEMS = 16,
    localparam int SW = idx_w(ROWS),
    localparam int EW = idx_w(ROW_ELEMS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [EW-1:0] wr_idx,
    input  word_t         wr_data,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_slot,
    input  logic [EW-1:0] rd_idx,
    output word_t         rd_data
);

    word_t mem [ROWS][ROW_ELEMS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot][wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_slot][rd_idx];

    // R3: reads address only rows and words that exist
    a_r3_read_in_range: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_slot) < ROWS) && (int'(rd_idx) < ROW_ELEMS));

    // R3: writes land inside the store
    a_r3_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_slot) < ROWS) && (int'(wr_idx) < ROW_ELEMS));

endmodule

// File: rtl/cwf_in_tracker.sv
module cwf_in_tracker
    import cwf_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int CH    = 2,
    parameter int KH    = 3,
    localparam int CW = idx_w(IMG_W),
    localparam int RW = idx_w(IMG_H),
    localparam int HW = idx_w(CH),
    localparam int SW = idx_w(KH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    output logic [CW-1:0] col,
    output logic [HW-1:0] chn,
    output logic [RW-1:0] row,
    output logic [SW-1:0] slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= '0;
            chn  <= '0;
            row  <= '0;
            slot <= '0;
        end else if (take) begin
            if (int'(chn) == CH - 1) begin
                chn <= '0;
                if (int'(col) == IMG_W - 1) begin
                    col <= '0;
                    if (int'(row) == IMG_H - 1) begin
                        row  <= '0;
                        slot <= '0;
                    end else begin
                        row  <= row + 1'b1;
                        slot <= (int'(slot) == KH - 1) ? '0 : slot + 1'b1;
                    end
                end else begin
                    col <= col + 1'b1;
                end
            end else begin
                chn <= chn + 1'b1;
            end
        end
    end

    // R5: the write slot always follows the input row modulo kernel height
    a_r5_slot_tracks_row: assert property (@(posedge clk) disable iff (rst)
        int'(slot) == (int'(row) % KH));

endmodule

// File: rtl/cwf_win_walker.sv
module cwf_win_walker
    import cwf_pkg::*;
#(
    parameter int KH    = 3,
    parameter int KW    = 3,
    parameter int CH    = 2,
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    localparam int OW  = IMG_W - KW + 1,
    localparam int OH  = IMG_H - KH + 1,
    localparam int YW  = idx_w(KH),
    localparam int XW  = idx_w(KW),
    localparam int HW  = idx_w(CH),
    localparam int OXW = idx_w(OW),
    localparam int OYW = idx_w(OH),
    localparam int SW  = idx_w(KH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    output logic [YW-1:0]  ky,
    output logic [XW-1:0]  kx,
    output logic [HW-1:0]  kc,
    output logic [OXW-1:0] ox,
    output logic [OYW-1:0] oy,
    output logic [SW-1:0]  top_slot,
    output logic           beat_last
);

    logic row_end;
    logic frame_end;

    assign beat_last = (int'(ky) == KH - 1) && (int'(kx) == KW - 1) && (int'(kc) == CH - 1);
    assign row_end   = beat_last && (int'(ox) == OW - 1);
    assign frame_end = row_end && (int'(oy) == OH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ky       <= '0;
            kx       <= '0;
            kc       <= '0;
            ox       <= '0;
            oy       <= '0;
            top_slot <= '0;
        end else if (step) begin
            if (beat_last) begin
                ky <= '0;
                kx <= '0;
                kc <= '0;
                if (frame_end) begin
                    ox       <= '0;
                    oy       <= '0;
                    top_slot <= '0;
                end else if (row_end) begin
                    ox       <= '0;
                    oy       <= oy + 1'b1;
                    top_slot <= (int'(top_slot) == KH - 1) ? '0 : top_slot + 1'b1;
                end else begin
                    ox <= ox + 1'b1;
                end
            end else if (int'(kc) == CH - 1) begin
                kc <= '0;
                if (int'(kx) == KW - 1) begin
                    kx <= '0;
                    ky <= ky + 1'b1;
                end else begin
                    kx <= kx + 1'b1;
                end
            end else begin
                kc <= kc + 1'b1;
            end
        end
    end

    // R6: output positions stay inside the valid-convolution area
    a_r6_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        (int'(ox) < OW) && (int'(oy) < OH));

    // R6: the top row slot follows the output row modulo kernel height
    a_r6_top_slot_tracks: assert property (@(posedge clk) disable iff (rst)
        int'(top_slot) == (int'(oy) % KH));

endmodule

// File: rtl/conv_window_feeder.sv
module conv_window_feeder
    import cwf_pkg::*;
#(
    parameter int KH    = 3,
    parameter int KW    = 3,
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int CH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              win_valid,
    input  logic              win_ready,
    output logic [WORD_W-1:0] win_data,
    output logic              win_last
);

    localparam int ROW_ELEMS = IMG_W * CH;
    localparam int OW  = IMG_W - KW + 1;
    localparam int OH  = IMG_H - KH + 1;
    localparam int CW  = idx_w(IMG_W);
    localparam int RW  = idx_w(IMG_H);
    localparam int HW  = idx_w(CH);
    localparam int SW  = idx_w(KH);
    localparam int EW  = idx_w(ROW_ELEMS);
    localparam int YW  = idx_w(KH);
    localparam int XW  = idx_w(KW);
    localparam int OXW = idx_w(OW);
    localparam int OYW = idx_w(OH);

    phase_e phase_q;

    logic take;
    logic step;
    logic fill_done;

    logic [CW-1:0]  in_col;
    logic [HW-1:0]  in_chn;
    logic [RW-1:0]  in_row;
    logic [SW-1:0]  in_slot;

    logic [YW-1:0]  ky;
    logic [XW-1:0]  kx;
    logic [HW-1:0]  kc;
    logic [OXW-1:0] ox;
    logic [OYW-1:0] oy;
    logic [SW-1:0]  top_slot;
    logic           beat_last;

    logic [EW-1:0]  wr_idx;
    logic [EW-1:0]  rd_idx;
    logic [SW-1:0]  rd_slot;
    int             slot_sum;

    assign in_ready  = (phase_q == PH_FILL);
    assign win_valid = (phase_q == PH_EMIT);
    assign take      = in_valid && in_ready;
    assign step      = win_valid && win_ready;
    assign win_last  = win_valid && beat_last;

    // the word just taken completes the pending window
    assign fill_done = take
                    && (int'(in_row) == int'(oy) + KH - 1)
                    && (int'(in_col) == int'(ox) + KW - 1)
                    && (int'(in_chn) == CH - 1);

    assign wr_idx   = EW'(int'(in_col) * CH + int'(in_chn));
    assign rd_idx   = EW'((int'(ox) + int'(kx)) * CH + int'(kc));
    assign slot_sum = int'(top_slot) + int'(ky);
    assign rd_slot  = SW'((slot_sum >= KH) ? slot_sum - KH : slot_sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
        end else begin
            case (phase_q)
                PH_FILL: if (fill_done)         phase_q <= PH_EMIT;
                PH_EMIT: if (step && beat_last) phase_q <= PH_FILL;
                default:                        phase_q <= PH_FILL;
            endcase
        end
    end

    cwf_in_tracker #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .CH    (CH),
        .KH    (KH)
    ) u_track (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .col  (in_col),
        .chn  (in_chn),
        .row  (in_row),
        .slot (in_slot)
    );

    cwf_win_walker #(
        .KH    (KH),
        .KW    (KW),
        .CH    (CH),
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .ky        (ky),
        .kx        (kx),
        .kc        (kc),
        .ox        (ox),
        .oy        (oy),
        .top_slot  (top_slot),
        .beat_last (beat_last)
    );

    cwf_row_store #(
        .ROWS      (KH),
        .ROW_ELEMS (ROW_ELEMS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_slot (in_slot),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .rd_en   (win_valid),
        .rd_slot (rd_slot),
        .rd_idx  (rd_idx),
        .rd_data (win_data)
    );

    // R7: a stalled element is held unchanged
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_ready) |=> (win_valid && $stable(win_data) && $stable(win_last)));

    // R2: emitting starts only in the cycle after an input word was accepted
    a_r2_emit_after_take: assert property (@(posedge clk) disable iff (rst)
        $rose(win_valid) |-> $past(take));

    // R4: handing over the last element returns the block to filling
    a_r4_last_ends_emit: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_ready && win_last) |=> (in_ready && !win_valid));

    // R8: a window never begins while its rows are still incomplete
    a_r8_fill_before_emit: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !fill_done) |=> in_ready);

endmodule

// File: tb/conv_window_feeder_test.sv
module conv_window_feeder_test;

    localparam int KH    = 3;
    localparam int KW    = 3;
    localparam int IMG_W = 8;
    localparam int IMG_H = 6;
    localparam int CH    = 2;
    localparam int OW    = IMG_W - KW + 1;
    localparam int OH    = IMG_H - KH + 1;
    localparam int FRAME = IMG_W * IMG_H * CH;
    localparam int WPF   = OW * OH;
    localparam int EPW   = KH * KW * CH;
    localparam int NF    = 3;
    localparam int LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        win_valid;
    logic        win_ready = 1'b0;
    logic [15:0] win_data;
    logic        win_last;

    always #4 clk = ~clk;

    conv_window_feeder #(
        .KH    (KH),
        .KW    (KW),
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .CH    (CH)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .win_valid (win_valid),
        .win_ready (win_ready),
        .win_data  (win_data),
        .win_last  (win_last)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] pix [NF][FRAME];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int gw, input int e);
        int f  = gw / WPF;
        int w  = gw % WPF;
        int oy = w / OW;
        int ox = w % OW;
        int ky = e / (KW * CH);
        int kx = (e / CH) % KW;
        int c  = e % CH;
        return pix[f][((oy + ky) * IMG_W + (ox + kx)) * CH + c];
    endfunction

    function automatic int exp_taken(input int gw);
        int f  = gw / WPF;
        int w  = gw % WPF;
        int oy = w / OW;
        int ox = w % OW;
        return f * FRAME + ((oy + KH - 1) * IMG_W + ox + KW - 1) * CH + CH;
    endfunction

    initial begin
        int in_idx = 0;
        int gw = 0;
        int beat = 0;
        int cycle = 0;
        bit stalled = 0;
        logic [15:0] held_data = '0;
        logic held_last = 0;
        bit timed_out = 0;

        void'($urandom(32'hC0DE5EED));
        for (int f = 0; f < NF; f++) begin
            for (int i = 0; i < FRAME; i++) begin
                pix[f][i] = 16'($urandom);
            end
        end
        pix[0][0]         = 16'hFFFF;
        pix[0][1]         = 16'h0000;
        pix[0][IMG_W * CH + 3] = 16'h8000;
        pix[0][FRAME - 1] = 16'h7FFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(win_valid == 1'b0, "R1 win_valid after reset", int'(win_valid), 0);

        while (gw < NF * WPF && !timed_out) begin
            // drive: first frame directed (always valid/ready), later frames random
            if (in_idx < NF * FRAME) begin
                in_valid = (in_idx < FRAME) ? 1'b1 : (($urandom % 10) < 7);
                in_data  = pix[in_idx / FRAME][in_idx % FRAME];
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
            win_ready = (gw < WPF) ? 1'b1 : (($urandom % 10) < 6);
            #1;

            if (stalled) begin
                check(win_valid == 1'b1, "R7 valid held in stall", int'(win_valid), 1);
                check(win_data == held_data, "R7 data held in stall", int'(win_data), int'(held_data));
                check(win_last == held_last, "R7 last held in stall", int'(win_last), int'(held_last));
            end
            check(!(in_ready && win_valid), "R2 phases exclusive", int'(in_ready && win_valid), 0);

            if (win_valid) begin
                if (beat == 0) begin
                    if (gw % WPF == 0 && gw > 0)
                        check(in_idx == exp_taken(gw), "R8 fresh fill for new frame", in_idx, exp_taken(gw));
                    else if (gw % WPF == 0)
                        check(in_idx == exp_taken(gw), "R2 initial fill count", in_idx, exp_taken(gw));
                    else
                        check(in_idx == exp_taken(gw), "R5 inputs between windows", in_idx, exp_taken(gw));
                end
                check(win_data == exp_word(gw, beat), "R3 R9 window element word",
                      int'(win_data), int'(exp_word(gw, beat)));
                check(win_last == (beat == EPW - 1), "R4 last flag", int'(win_last), int'(beat == EPW - 1));
                stalled   = !win_ready;
                held_data = win_data;
                held_last = win_last;
                if (win_ready) begin
                    beat++;
                    if (beat == EPW) begin
                        beat = 0;
                        gw++;
                    end
                end
            end else begin
                stalled = 0;
            end
            if (in_valid && in_ready) in_idx++;

            @(posedge clk);
            @(negedge clk);
            cycle++;
            if (cycle > LIMIT) timed_out = 1;
        end

        if (timed_out) begin
            check(1'b0, "R6 watchdog expired", gw, NF * WPF);
        end else begin
            in_valid  = 1'b0;
            win_ready = 1'b0;
            #1;
            check(in_idx == NF * FRAME, "R6 all input consumed by last window", in_idx, NF * FRAME);
            check(gw == NF * WPF, "R6 window count", gw, NF * WPF);
            check(in_ready == 1'b1, "R8 back to fill after frame", int'(in_ready), 1);
            check(win_valid == 1'b0, "R8 no window pending after frame", int'(win_valid), 0);
            repeat (4) @(posedge clk);
            @(negedge clk);
            #1;
            check(win_valid == 1'b0, "R8 idle without input", int'(win_valid), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule